// File: doc/BRIEF.md
# Dual-Mode 3x3 Matrix / Convolution Datapath

This block is a pipelined arithmetic engine with three 8-bit pixel inputs. It runs in one of two modes. In matrix mode the three inputs are treated as the components of a single pixel, for example three colour channels. Each of three multiply-add lanes forms the dot product of that vector with one row of a 3x3 signed coefficient matrix, and the three results leave on separate outputs. In convolution mode each input carries pixels from its own image line. Every lane keeps a short horizontal history of its line, weights three neighbouring pixels with its coefficient row, and the three lane results are added into one 3x3 filtered value.

The nine coefficients sit in a static register bank. The bank takes either one byte per write cycle, walking from the top-row coefficient down to the bottom one, or all nine bytes in a single cycle. A new sample may enter on every clock. Each result appears exactly six cycles after its sample, and a valid flag travels with it. The mode and the coefficients must stay still while samples are in flight.

Top module: `mat3_conv_dp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld` and all data outputs are cleared. All nine coefficients are cleared, the tap history is cleared, and the byte-load index points at C22.
- R2: With `mode_conv`=0, a valid sample gives `mat_outR` = CR2*`in2` + CR1*`in1` + CR0*`in0` for R in 2..0. Pixels are unsigned and coefficients are 8-bit two's complement.
- R3: With `mode_conv`=1, `conv_out` = sum over lines R and taps T of CRT * xR[n-T], where xR is the pixel stream on input `inR`. The history advances only on cycles with `in_vld`=1, in either mode, and it starts at zero after reset.
- R4: Results are kept at full precision with no saturation: 18-bit signed lane outputs and a 20-bit signed `conv_out`. In convolution mode `mat_outR` carries line R's partial sum, and `conv_out` always equals the sum of the three lane outputs.
- R5: A sample presented with `in_vld`=1 before clock edge k produces its result, with `out_vld`=1, right after edge k+5 (six cycles later). `out_vld` is `in_vld` delayed by six cycles.
- R6: Back-to-back valid samples, one per clock, each give their own correct result with no stall.
- R7: `cfg_wr`=1 with `cfg_par`=1 loads all nine coefficients at once. CRT is taken from `cfg_all[(3R+T)*8 +: 8]`.
- R8: `cfg_wr`=1 with `cfg_par`=0 writes `cfg_byte` to the coefficient at the load index, then steps the index. The order is C22, C21, C20, C12, C11, C10, C02, C01, C00.
- R9: `cfg_start`=1 returns the index to C22. If a byte write happens in the same cycle, that byte goes to C22 and the index moves on to C21.
- R10: A byte write at C00 wraps the index back to C22.
- R11: The coefficients do not change on cycles with `cfg_wr`=0, whatever `cfg_byte`, `cfg_all`, `cfg_par` and `cfg_start` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_conv | input | 1 | 0 = matrix mode, 1 = convolution mode |
| in_vld | input | 1 | Sample on in2..in0 is valid |
| in2 | input | 8 | Pixel input, row/line 2 |
| in1 | input | 8 | Pixel input, row/line 1 |
| in0 | input | 8 | Pixel input, row/line 0 |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_par | input | 1 | 1 = all-at-once load, 0 = one byte per write |
| cfg_start | input | 1 | Return byte-load index to C22 |
| cfg_byte | input | 8 | Coefficient byte for byte-wise load |
| cfg_all | input | 72 | All nine coefficients, CRT at bits (3R+T)*8 |
| out_vld | output | 1 | Result outputs are valid |
| mat_out2 | output | 18 | Lane 2 result (signed) |
| mat_out1 | output | 18 | Lane 1 result (signed) |
| mat_out0 | output | 18 | Lane 0 result (signed) |
| conv_out | output | 20 | Sum of the three lanes (signed) |

## Verification
The properties assume that `rst_n` is held low for at least one edge before the first sample. They also assume that `mode_conv` and the coefficient bank stay unchanged whenever samples are inside the six-stage pipe. Results computed across such a change are undefined, so no property depends on them. The stimulus keeps to this by letting the pipe drain for eight idle cycles before every mode switch and every coefficient load. Inside a run, it mixes random gaps in `in_vld` with fully back-to-back bursts.

// File: rtl/mcd_pkg.sv
// Shared constants and types for the dual-mode 3x3 datapath.
// Assumes a fixed 3x3 geometry; widths stay parameters of the modules.
package mcd_pkg;
    localparam int NUM_LANE = 3;
    localparam int NUM_TAP  = 3;
    localparam int PIPE_LAT = 6;

    typedef enum logic {
        MODE_MATRIX = 1'b0,
        MODE_CONV   = 1'b1
    } mode_e;
endpackage

// File: rtl/mcd_coef_bank.sv
// Static coefficient register bank with two load styles.
// Whole-bank load takes every entry from a flat bus in one cycle.
// Byte load writes one entry per strobe at an index that counts down
// from the last entry to entry 0 and then wraps.
// Assumes the consumer reads coef_flat only while no samples are in flight.
module mcd_coef_bank #(
    parameter int COEF_W = 8,
    parameter int N_COEF = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     par_sel,
    input  logic                     idx_restart,
    input  logic [COEF_W-1:0]        byte_in,
    input  logic [N_COEF*COEF_W-1:0] all_in,
    output logic [N_COEF*COEF_W-1:0] coef_flat
);
    localparam int              IDX_W   = $clog2(N_COEF);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(N_COEF - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_eff;
    logic [COEF_W-1:0] bank_q [N_COEF];
    logic              byte_wr;

    // Index used by this cycle's byte write; a restart overrides it.
    assign idx_eff = idx_restart ? IDX_TOP : idx_q;
    assign byte_wr = wr_en && !par_sel;

    // Load index: step down after each byte write, wrap after entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_TOP;
        end else if (byte_wr) begin
            idx_q <= (idx_eff == '0) ? IDX_TOP : idx_eff - 1'b1;
        end else if (idx_restart) begin
            idx_q <= IDX_TOP;
        end
    end

    for (genvar k = 0; k < N_COEF; k++) begin : g_entry
        // One coefficient entry: whole-bank load or byte load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[k] <= '0;
            end else if (wr_en && par_sel) begin
                bank_q[k] <= all_in[k*COEF_W +: COEF_W];
            end else if (byte_wr && (idx_eff == IDX_W'(k))) begin
                bank_q[k] <= byte_in;
            end
        end
        assign coef_flat[k*COEF_W +: COEF_W] = bank_q[k];
    end

    // R7: a whole-bank write shows up in the bank one edge later.
    a_r7_par_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_en && par_sel) |-> coef_flat == $past(all_in));

    // R8: a byte write away from entry 0 moves the index down by one.
    a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && byte_wr && !idx_restart && idx_q != '0)
        |-> idx_q == $past(idx_q) - 1'b1);

    // R9: a restart without a write parks the index on the top entry.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && idx_restart && !wr_en) |-> idx_q == IDX_TOP);

    // R10: a byte write at entry 0 wraps the index to the top.
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && byte_wr && !idx_restart && idx_q == '0) |-> idx_q == IDX_TOP);

    // R11: with no write strobe the bank keeps its contents.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !wr_en) |-> $stable(coef_flat));
endmodule

// File: rtl/mcd_tap_line.sv
// Horizontal tap history for one pixel input.
// Tap 0 is the newest accepted pixel and tap N_TAP-1 the oldest.
// The history shifts only on accepted samples, so gaps in the valid
// stream do not open holes in the window.
module mcd_tap_line #(
    parameter int PIX_W = 8,
    parameter int N_TAP = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic [PIX_W-1:0]       pix_in,
    output logic [N_TAP*PIX_W-1:0] taps_flat
);
    logic [PIX_W-1:0] tap_q [N_TAP];

    for (genvar k = 0; k < N_TAP; k++) begin : g_tap
        if (k == 0) begin : g_head
            // Newest tap captures the incoming pixel.
            always_ff @(posedge clk) begin
                if (!rst_n)        tap_q[k] <= '0;
                else if (shift_en) tap_q[k] <= pix_in;
            end
        end else begin : g_body
            // Older taps take the value of their younger neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n)        tap_q[k] <= '0;
                else if (shift_en) tap_q[k] <= tap_q[k-1];
            end
        end
        assign taps_flat[k*PIX_W +: PIX_W] = tap_q[k];
    end

    // R3: a cycle with no accepted sample leaves the window unchanged.
    a_r3_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !shift_en) |-> $stable(taps_flat));
endmodule

// File: rtl/mcd_lane.sv
// One multiply-add lane: registered operands, signed products, and a
// two-step adder tree. Four register stages from op_in to lane_sum.
// Pixels are unsigned and coefficients two's complement. coef_in is
// assumed static while samples are in flight.
module mcd_lane #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int N_TAP  = 3,
    parameter int LANE_W = PIX_W + COEF_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TAP*PIX_W-1:0]    op_in,
    input  logic [N_TAP*COEF_W-1:0]   coef_in,
    output logic signed [LANE_W-1:0]  lane_sum
);
    localparam int PROD_W = PIX_W + COEF_W;

    logic [PIX_W-1:0]         op_q   [N_TAP];
    logic signed [PROD_W-1:0] prod_q [N_TAP];
    logic signed [LANE_W-1:0] pair_q;
    logic signed [LANE_W-1:0] rest_q;
    logic signed [LANE_W-1:0] rest_c;
    logic signed [LANE_W-1:0] sum_q;

    // Operand stage: hold the selected pixels.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_TAP; k++) begin
            if (!rst_n) op_q[k] <= '0;
            else        op_q[k] <= op_in[k*PIX_W +: PIX_W];
        end
    end

    // Product stage: unsigned pixel times signed coefficient.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_TAP; k++) begin
            if (!rst_n) prod_q[k] <= '0;
            else        prod_q[k] <= PROD_W'($signed({1'b0, op_q[k]}))
                                   * PROD_W'($signed(coef_in[k*COEF_W +: COEF_W]));
        end
    end

    // Sum of the products beyond the first pair.
    always_comb begin
        rest_c = '0;
        for (int k = 2; k < N_TAP; k++) begin
            rest_c = rest_c + LANE_W'(prod_q[k]);
        end
    end

    // First adder stage: one pair plus the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
            rest_q <= '0;
        end else begin
            pair_q <= LANE_W'(prod_q[0]) + LANE_W'(prod_q[1]);
            rest_q <= rest_c;
        end
    end

    // Second adder stage: the lane dot product.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= pair_q + rest_q;
    end

    assign lane_sum = sum_q;
endmodule

// File: rtl/mat3_conv_dp.sv
// Dual-mode 3x3 datapath top.
// Stage 1 is the tap history per line. The mode multiplexer then feeds
// three lanes (stages 2-5). Stage 6 registers the lane results and their
// sum. Matrix mode uses the newest tap of every line as the pixel vector;
// convolution mode gives each lane the taps of its own line.
// Assumes mode and coefficients are changed only when the pipe is empty.
module mat3_conv_dp #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_conv,
    input  logic                              in_vld,
    input  logic [PIX_W-1:0]                  in2,
    input  logic [PIX_W-1:0]                  in1,
    input  logic [PIX_W-1:0]                  in0,
    input  logic                              cfg_wr,
    input  logic                              cfg_par,
    input  logic                              cfg_start,
    input  logic [COEF_W-1:0]                 cfg_byte,
    input  logic [9*COEF_W-1:0]               cfg_all,
    output logic                              out_vld,
    output logic signed [PIX_W+COEF_W+1:0]    mat_out2,
    output logic signed [PIX_W+COEF_W+1:0]    mat_out1,
    output logic signed [PIX_W+COEF_W+1:0]    mat_out0,
    output logic signed [PIX_W+COEF_W+3:0]    conv_out
);
    import mcd_pkg::*;

    localparam int LANE_W = PIX_W + COEF_W + 2;
    localparam int CONV_W = PIX_W + COEF_W + 4;
    localparam int N_COEF = NUM_LANE * NUM_TAP;
    localparam int CNT_W  = $clog2(PIPE_LAT + 1);

    mode_e                        mode_s;
    logic [PIX_W-1:0]             pix_in   [NUM_LANE];
    logic [NUM_TAP*PIX_W-1:0]     taps     [NUM_LANE];
    logic [NUM_TAP*PIX_W-1:0]     ops      [NUM_LANE];
    logic signed [LANE_W-1:0]     lane_sum [NUM_LANE];
    logic signed [LANE_W-1:0]     mat_q    [NUM_LANE];
    logic signed [CONV_W-1:0]     conv_c;
    logic signed [CONV_W-1:0]     conv_q;
    logic [N_COEF*COEF_W-1:0]     coef_flat;
    logic [PIPE_LAT-1:0]          vld_sr;
    logic [CNT_W-1:0]             since_rst;

    assign mode_s    = mode_e'(mode_conv);
    assign pix_in[0] = in0;
    assign pix_in[1] = in1;
    assign pix_in[2] = in2;

    mcd_coef_bank #(
        .COEF_W (COEF_W),
        .N_COEF (N_COEF)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .par_sel     (cfg_par),
        .idx_restart (cfg_start),
        .byte_in     (cfg_byte),
        .all_in      (cfg_all),
        .coef_flat   (coef_flat)
    );

    for (genvar r = 0; r < NUM_LANE; r++) begin : g_lane
        mcd_tap_line #(
            .PIX_W (PIX_W),
            .N_TAP (NUM_TAP)
        ) u_taps (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (in_vld),
            .pix_in    (pix_in[r]),
            .taps_flat (taps[r])
        );

        // Mode multiplexer: own-line taps or the newest tap of each line.
        always_comb begin
            for (int t = 0; t < NUM_TAP; t++) begin
                if (mode_s == MODE_CONV) ops[r][t*PIX_W +: PIX_W] = taps[r][t*PIX_W +: PIX_W];
                else                     ops[r][t*PIX_W +: PIX_W] = taps[t][0 +: PIX_W];
            end
        end

        mcd_lane #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W),
            .N_TAP  (NUM_TAP),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_in    (ops[r]),
            .coef_in  (coef_flat[r*NUM_TAP*COEF_W +: NUM_TAP*COEF_W]),
            .lane_sum (lane_sum[r])
        );
    end

    // Cross-lane adder for the convolution result.
    always_comb begin
        conv_c = '0;
        for (int r = 0; r < NUM_LANE; r++) begin
            conv_c = conv_c + CONV_W'(lane_sum[r]);
        end
    end

    // Output stage: register lane results and their sum.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_LANE; r++) begin
            if (!rst_n) mat_q[r] <= '0;
            else        mat_q[r] <= lane_sum[r];
        end
        if (!rst_n) conv_q <= '0;
        else        conv_q <= conv_c;
    end

    // Valid pipe aligned with the six data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[PIPE_LAT-2:0], in_vld};
    end

    // Cycles since reset, saturating; used only to qualify the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_rst <= '0;
        else if (since_rst != CNT_W'(PIPE_LAT)) since_rst <= since_rst + 1'b1;
    end

    assign out_vld  = vld_sr[PIPE_LAT-1];
    assign mat_out0 = mat_q[0];
    assign mat_out1 = mat_q[1];
    assign mat_out2 = mat_q[2];
    assign conv_out = conv_q;

    // R5: out_vld is in_vld six edges later once the pipe has filled.
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CNT_W'(PIPE_LAT)) |-> out_vld == $past(in_vld, 6));

    // R4: the combined result equals the sum of the three lane outputs.
    a_r4_conv_is_lane_sum: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> conv_out == CONV_W'(mat_out2) + CONV_W'(mat_out1) + CONV_W'(mat_out0));

    // R1: right after a reset edge the outputs are cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_vld && conv_out == '0 && mat_out0 == '0));
endmodule

// File: tb/mat3_conv_dp_tb.sv
module mat3_conv_dp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_conv = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  in2 = '0, in1 = '0, in0 = '0;
    logic        cfg_wr = 1'b0, cfg_par = 1'b0, cfg_start = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic [71:0] cfg_all = '0;
    logic        out_vld;
    logic signed [17:0] mat_out2, mat_out1, mat_out0;
    logic signed [19:0] conv_out;

    mat3_conv_dp u_dut (
        .clk(clk), .rst_n(rst_n), .mode_conv(mode_conv), .in_vld(in_vld),
        .in2(in2), .in1(in1), .in0(in0),
        .cfg_wr(cfg_wr), .cfg_par(cfg_par), .cfg_start(cfg_start),
        .cfg_byte(cfg_byte), .cfg_all(cfg_all),
        .out_vld(out_vld), .mat_out2(mat_out2), .mat_out1(mat_out1),
        .mat_out0(mat_out0), .conv_out(conv_out)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    // Bench model state.
    int bm [9];          // coefficient C(r,t) at index 3r+t
    int bptr = 8;        // byte-load index
    int hist [3][3];     // hist[r][t] = line r pixel, t samples back
    int q_m [256][3];
    int q_c [256];
    int q_cyc [256];
    bit q_conv [256];
    string q_tag [256];
    int wr_i = 0, rd_i = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output checker: compares every valid result with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && !done && out_vld) begin
            if (rd_i == wr_i) begin
                chk(1'b0, "R5 unexpected out_vld", 1, 0);
            end else begin
                int k;
                k = rd_i % 256;
                chk(cyc - q_cyc[k] == 6, {q_tag[k], " R5 latency"}, cyc - q_cyc[k], 6);
                chk(int'(mat_out2) == q_m[k][2], {q_tag[k], q_conv[k] ? " R4 lane2" : " R2 row2"}, int'(mat_out2), q_m[k][2]);
                chk(int'(mat_out1) == q_m[k][1], {q_tag[k], q_conv[k] ? " R4 lane1" : " R2 row1"}, int'(mat_out1), q_m[k][1]);
                chk(int'(mat_out0) == q_m[k][0], {q_tag[k], q_conv[k] ? " R4 lane0" : " R2 row0"}, int'(mat_out0), q_m[k][0]);
                chk(int'(conv_out) == q_c[k], {q_tag[k], q_conv[k] ? " R3 conv" : " R4 sum"}, int'(conv_out), q_c[k]);
                rd_i++;
            end
        end
    end

    function automatic int s8(input int b);
        return (b > 127) ? b - 256 : b;
    endfunction

    task automatic clear_inputs();
        in_vld = 1'b0; cfg_wr = 1'b0; cfg_start = 1'b0;
    endtask

    // One sample cycle; queues the expected result when valid.
    task automatic send(input bit v, input int p2, input int p1, input int p0, input string tag);
        int px [3];
        int k;
        @(negedge clk);
        clear_inputs();
        in_vld = v; in2 = p2[7:0]; in1 = p1[7:0]; in0 = p0[7:0];
        if (v) begin
            px[0] = p0; px[1] = p1; px[2] = p2;
            for (int r = 0; r < 3; r++) begin
                hist[r][2] = hist[r][1]; hist[r][1] = hist[r][0]; hist[r][0] = px[r];
            end
            k = wr_i % 256;
            q_c[k] = 0;
            for (int r = 0; r < 3; r++) begin
                q_m[k][r] = 0;
                for (int t = 0; t < 3; t++) begin
                    q_m[k][r] += bm[3*r+t] * (mode_conv ? hist[r][t] : px[t]);
                end
                q_c[k] += q_m[k][r];
            end
            q_cyc[k]  = cyc;
            q_conv[k] = mode_conv;
            q_tag[k]  = tag;
            wr_i++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(1'b0, 0, 0, 0, "");
    endtask

    task automatic set_mode(input bit m);
        idle(8);
        @(negedge clk);
        clear_inputs();
        mode_conv = m;
    endtask

    task automatic load_byte(input int b, input bit st);
        int eff;
        @(negedge clk);
        clear_inputs();
        cfg_wr = 1'b1; cfg_par = 1'b0; cfg_start = st; cfg_byte = b[7:0];
        eff = st ? 8 : bptr;
        bm[eff] = s8(b);
        bptr = (eff == 0) ? 8 : eff - 1;
    endtask

    task automatic load_all(input int v [9]);
        @(negedge clk);
        clear_inputs();
        cfg_wr = 1'b1; cfg_par = 1'b1;
        for (int k = 0; k < 9; k++) begin
            cfg_all[k*8 +: 8] = v[k][7:0];
            bm[k] = s8(v[k]);
        end
    endtask

    task automatic rand_run(input int n, input int gap_pct, input string tag);
        for (int i = 0; i < n; i++) begin
            send(($urandom_range(0, 99) >= gap_pct), $urandom_range(0, 255),
                 $urandom_range(0, 255), $urandom_range(0, 255), tag);
        end
    endtask

    initial begin
        int vals [9];
        void'($urandom(32'd4242));
        for (int k = 0; k < 9; k++) bm[k] = 0;
        for (int r = 0; r < 3; r++) for (int t = 0; t < 3; t++) hist[r][t] = 0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
        chk(conv_out == 0, "R1 conv_out", int'(conv_out), 0);
        chk(mat_out2 == 0 && mat_out1 == 0 && mat_out0 == 0, "R1 mat outs", int'(mat_out2), 0);
        rst_n = 1'b1;
        send(1'b1, 200, 100, 50, "R1 zero coefs");
        idle(8);

        // R8 / R1: byte load from the reset index, no start pulse.
        for (int k = 0; k < 9; k++) load_byte($urandom_range(0, 255), 1'b0);
        idle(8);
        rand_run(40, 25, "R8");
        for (int i = 0; i < 12; i++)
            send(1'b1, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), "R6 burst");
        idle(8);

        // R7 extremes: every coefficient at the most negative value.
        for (int k = 0; k < 9; k++) vals[k] = 128;
        load_all(vals);
        idle(8);
        send(1'b1, 255, 255, 255, "R7 min coef");
        send(1'b1, 0, 0, 0, "R7 zero pix");
        set_mode(1'b1);
        for (int i = 0; i < 3; i++) send(1'b1, 255, 255, 255, "R4 full negative");
        idle(8);
        for (int k = 0; k < 9; k++) vals[k] = 127;
        load_all(vals);
        idle(8);
        for (int i = 0; i < 3; i++) send(1'b1, 255, 255, 255, "R4 full positive");
        idle(8);

        // R3: random convolution with gaps and a random kernel.
        for (int k = 0; k < 9; k++) vals[k] = $urandom_range(0, 255);
        load_all(vals);
        idle(8);
        rand_run(60, 30, "R3");
        idle(8);

        // R9: restart partway through a byte load, restart with write.
        for (int k = 0; k < 3; k++) load_byte($urandom_range(0, 255), 1'b0);
        load_byte($urandom_range(0, 255), 1'b1);
        for (int k = 0; k < 8; k++) load_byte($urandom_range(0, 255), 1'b0);
        idle(8);
        rand_run(30, 20, "R9");
        idle(8);

        // R10: one more byte wraps to C22.
        load_byte($urandom_range(0, 255), 1'b0);
        load_byte($urandom_range(0, 255), 1'b0);
        set_mode(1'b0);
        rand_run(30, 20, "R10");
        idle(8);

        // R11: busy config inputs without a write strobe.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            clear_inputs();
            cfg_byte = $urandom_range(0, 255);
            cfg_all = {$urandom(), $urandom(), $urandom()};
            cfg_par = $urandom_range(0, 1);
            cfg_start = $urandom_range(0, 1);
        end
        @(negedge clk);
        clear_inputs();
        send(1'b1, 1, 0, 0, "R11 col2");
        send(1'b1, 0, 1, 0, "R11 col1");
        send(1'b1, 0, 0, 1, "R11 col0");
        rand_run(20, 10, "R11");
        idle(10);

        chk(rd_i == wr_i, "R5 all results delivered", rd_i, wr_i);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule